// File: doc/BRIEF.md
# Dual-Reload PWM and One-Shot Timer

This block is one output timer channel. It has a down-counter whose width is set by a parameter (16 bits by default) and two reload values that software writes. It has two modes.

In PWM mode, a start loads reload 0. Each time the counter runs out, the next interval comes from the other reload value, so the output spends reload 0 + 1 ticks at one level and reload 1 + 1 ticks at the other. The output flip-flop inverts at start and at every underflow. An interrupt strobe marks every second underflow, which is the end of each full period.

In one-shot mode, the block inverts its output at start and again at the first underflow. It raises the interrupt at that underflow and then goes idle.

Counting advances only on cycles where the count-clock enable from an external prescaler is high. A start can come from two sources: a rising edge of the software enable, or a one-cycle trigger pulse from another timer. The start waits, pending, for the next count tick. Dropping the enable halts the channel on the next clock edge, wherever it is in the period.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset `out_o` is 0, `irq_o` is 0 and `cnt_o` is 0.
- R2: A start request is accepted only while the channel is idle. A start request is a rising edge of `en_i` or a high cycle of `trg_i`. It loads reload 0 into the counter on the next cycle with `tick_i` high, and `out_o` inverts on that same edge.
- R3: The counter changes only on cycles with `tick_i` high. While running and above zero, it steps down by exactly one per tick.
- R4: In PWM mode (`mode_i` = 0), the intervals between output changes are, in order: reload 0 + 1 ticks, reload 1 + 1 ticks, reload 0 + 1 ticks, and so on in strict alternation. An underflow is a tick that finds the counter at 0.
- R5: In PWM mode, `out_o` inverts at start and at every underflow, and at no other time.
- R6: In PWM mode, `irq_o` is a one-cycle pulse. It is asserted on the edge of the 2nd, 4th, 6th and later even-numbered underflows after a start, and never on odd ones.
- R7: A falling edge of `en_i` stops the channel on the next clock edge. The counter and `out_o` then hold their values, and a pending start is cancelled.
- R8: In one-shot mode (`mode_i` = 1), `out_o` inverts at start and once more after reload 0 + 1 ticks. `irq_o` pulses on that second edge. The counter then stays at 0 and the output makes no further changes.
- R9: The mode is captured only while the channel is idle with no start pending. A change on `mode_i` during a run has no effect on that run.
- R10: A start request that arrives while the channel is running is ignored. It does not restart or reshape the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-clock enable |
| en_i | input | 1 | Software enable level; rising edge starts, falling edge stops |
| trg_i | input | 1 | Start pulse from another timer |
| mode_i | input | 1 | 0 = PWM, 1 = one-shot |
| wr0_i | input | 1 | Write strobe for reload 0 |
| wr1_i | input | 1 | Write strobe for reload 1 |
| wdata_i | input | W | Reload write data |
| out_o | output | 1 | Output flip-flop level |
| irq_o | output | 1 | Interrupt strobe, one cycle |
| cnt_o | output | W | Current counter value |

## Verification
The bench builds the channel with W = 4, so a reload of 15 is the largest value and the counter stays small. It sweeps every pair of reloads from {0, 1, 2, 3, 15} in PWM mode and every reload from that set in one-shot mode. Each interval length and each interrupt position is compared with reload + 1 ticks. With a tick on every third cycle, the same arithmetic is scaled by three. Directed runs cover a disable in mid-period, a start cancelled while pending, a trigger-driven start, and a mode change or trigger pulse arriving during a run.

// File: rtl/dual_reload_timer_pkg.sv
package dual_reload_timer_pkg;
  typedef enum logic {
    MODE_PWM     = 1'b0,
    MODE_ONESHOT = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/drt_regs.sv
module drt_regs #(
  parameter int W = 16,
  parameter int NREG = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [NREG-1:0] wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rld_o [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (wr_i[g]) q <= wdata_i;
    end
    assign rld_o[g] = q;
  end
endmodule

// File: rtl/drt_ctrl.sv
module drt_ctrl
  import dual_reload_timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      en_i,
  input  logic      trg_i,
  input  logic      mode_i,
  input  logic      run_i,
  output logic      load_o,
  output logic      stop_o,
  output tmr_mode_e mode_o
);
  logic en_d, pend_q;
  tmr_mode_e mode_q;
  logic rise, fall, req;

  assign rise   = en_i & ~en_d;
  assign fall   = ~en_i & en_d;
  assign req    = (rise | trg_i) & ~run_i & ~pend_q;
  assign load_o = pend_q & tick_i & ~fall;
  assign stop_o = fall;
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d   <= 1'b0;
      pend_q <= 1'b0;
      mode_q <= MODE_PWM;
    end else begin
      en_d <= en_i;
      if (fall || load_o) pend_q <= 1'b0;
      else if (req)       pend_q <= 1'b1;
      // mode only follows input while fully idle
      if (!run_i && !pend_q) mode_q <= tmr_mode_e'(mode_i);
    end
  end

  p_pend_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !tick_i && !fall |=> pend_q);
  p_mode_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) |-> $stable(mode_q));
endmodule

// File: rtl/drt_core.sv
module drt_core
  import dual_reload_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic         stop_i,
  input  tmr_mode_e    mode_i,
  input  logic [W-1:0] rld0_i,
  input  logic [W-1:0] rld1_i,
  output logic         run_o,
  output logic         out_o,
  output logic         irq_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic run_q, out_q, irq_q, sel_q, par_q;
  logic uflow;

  assign uflow = run_q & tick_i & ~load_i & ~stop_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      out_q <= 1'b0;
      irq_q <= 1'b0;
      sel_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (load_i) begin
        cnt_q <= rld0_i;
        run_q <= 1'b1;
        out_q <= ~out_q;
        sel_q <= 1'b1;
        par_q <= 1'b0;
      end else if (run_q && tick_i) begin
        if (cnt_q == '0) begin
          out_q <= ~out_q;
          if (mode_i == MODE_ONESHOT) begin
            run_q <= 1'b0;
            irq_q <= 1'b1;
          end else begin
            cnt_q <= sel_q ? rld1_i : rld0_i;
            sel_q <= ~sel_q;
            par_q <= ~par_q;
            irq_q <= par_q;  // even-numbered underflow
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign run_o = run_q;
  assign out_o = out_q;
  assign irq_o = irq_q;
  assign cnt_o = cnt_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tick_i && !load_i && !stop_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
  p_irq_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> out_q != $past(out_q));
  p_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q && $stable(out_q) && $stable(cnt_q));
  p_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow && mode_i == MODE_ONESHOT |=> !run_q && irq_q);
  p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !load_i |=> $stable(out_q));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dual_reload_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         trg_i,
  input  logic         mode_i,
  input  logic         wr0_i,
  input  logic         wr1_i,
  input  logic [W-1:0] wdata_i,
  output logic         out_o,
  output logic         irq_o,
  output logic [W-1:0] cnt_o
);
  localparam int NREG = 2;

  logic [W-1:0] rld [NREG];
  logic load, stop, run;
  tmr_mode_e mode;

  drt_regs #(.W(W), .NREG(NREG)) u_regs (
    .clk_i, .rst_ni,
    .wr_i    ({wr1_i, wr0_i}),
    .wdata_i,
    .rld_o   (rld)
  );

  drt_ctrl u_ctrl (
    .clk_i, .rst_ni, .tick_i, .en_i, .trg_i, .mode_i,
    .run_i  (run),
    .load_o (load),
    .stop_o (stop),
    .mode_o (mode)
  );

  drt_core #(.W(W)) u_core (
    .clk_i, .rst_ni, .tick_i,
    .load_i (load),
    .stop_i (stop),
    .mode_i (mode),
    .rld0_i (rld[0]),
    .rld1_i (rld[1]),
    .run_o  (run),
    .out_o, .irq_o, .cnt_o
  );
endmodule

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;
  localparam int W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b0, en_i = 1'b0, trg_i = 1'b0, mode_i = 1'b0;
  logic wr0_i = 1'b0, wr1_i = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic out_o, irq_o;
  logic [W-1:0] cnt_o;

  int errors = 0, checks = 0, cyc = 0, tper = 1, tdiv = 0, stray = 0;
  int seg_len [8];
  bit irq_at [8];

  dual_reload_timer #(.W(W)) uut (.*, .clk_i(clk));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   = (tdiv + 1 >= tper) ? 0 : tdiv + 1;
    tick_i = (tdiv == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int v);
    @(negedge clk);
    wdata_i = W'(v); wr0_i = (idx == 0); wr1_i = (idx == 1);
    @(negedge clk);
    wr0_i = 1'b0; wr1_i = 1'b0;
  endtask

  // toggle 0 is the start; seg_len[s] is ticks*tper between toggles s and s+1
  task automatic watch(int nseg);
    logic lv;
    int len;
    lv = out_o;
    for (int s = 0; s <= nseg; s++) begin
      len = 0;
      do begin
        @(negedge clk); len++;
        if (out_o == lv && irq_o) stray++;
      end while (out_o == lv && len < 400);
      irq_at[s] = irq_o;
      if (s > 0) seg_len[s-1] = len;
      lv = out_o;
    end
  endtask

  task automatic halt();
    @(negedge clk); en_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_pwm(int r0, int r1);
    wr(0, r0); wr(1, r1);
    mode_i = 1'b0; stray = 0;
    @(negedge clk); en_i = 1'b1;
    watch(4);
    chk(seg_len[0] == (r0+1)*tper, "R4 first interval", seg_len[0], (r0+1)*tper);
    chk(seg_len[1] == (r1+1)*tper, "R4 second interval", seg_len[1], (r1+1)*tper);
    chk(seg_len[2] == (r0+1)*tper, "R4 third interval", seg_len[2], (r0+1)*tper);
    chk(seg_len[3] == (r1+1)*tper, "R5 fourth interval", seg_len[3], (r1+1)*tper);
    chk(!irq_at[0] && !irq_at[1] && !irq_at[3], "R6 no irq on odd",
        int'(irq_at[0]) + int'(irq_at[1]) + int'(irq_at[3]), 0);
    chk(irq_at[2] && irq_at[4], "R6 irq on even", int'(irq_at[2]) + int'(irq_at[4]), 2);
    chk(stray == 0, "R6 stray irq", stray, 0);
    halt();
  endtask

  task automatic run_one(int r0);
    logic lv;
    wr(0, r0);
    mode_i = 1'b1; stray = 0;
    @(negedge clk); en_i = 1'b1;
    watch(1);
    chk(seg_len[0] == (r0+1)*tper, "R8 pulse width", seg_len[0], (r0+1)*tper);
    chk(irq_at[1] && !irq_at[0], "R8 irq at end", int'(irq_at[1]), 1);
    lv = out_o;
    repeat (40) begin
      @(negedge clk);
      if (out_o != lv || irq_o) stray++;
    end
    chk(stray == 0, "R8 stays idle", stray, 0);
    chk(cnt_o == 0, "R8 counter at zero", int'(cnt_o), 0);
    halt();
  endtask

  initial begin
    int vals [5] = '{0, 1, 2, 3, 15};
    logic lv;
    logic [W-1:0] c;
    int bad;
    #1;
    chk(out_o == 0 && irq_o == 0 && cnt_o == 0, "R1 reset state", int'(out_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk(out_o == 0 && irq_o == 0 && cnt_o == 0, "R1 after release", int'(cnt_o), 0);

    foreach (vals[i]) foreach (vals[j]) run_pwm(vals[i], vals[j]);
    foreach (vals[i]) run_one(vals[i]);

    tper = 3;  // R3: tick every third cycle
    run_pwm(2, 1);
    run_one(4);
    tper = 1;

    // R7: disable mid-period
    wr(0, 9); wr(1, 9); mode_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
    repeat (6) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    lv = out_o; c = cnt_o; bad = 0;
    chk(c != 0, "R7 stopped mid-count", int'(c), 1);
    repeat (30) begin
      @(negedge clk);
      if (out_o != lv || cnt_o != c || irq_o) bad++;
    end
    chk(bad == 0, "R7 hold after disable", bad, 0);

    // R7: pending start cancelled
    @(negedge clk); en_i = 1'b1;
    @(negedge clk); en_i = 1'b0;
    lv = out_o; bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (out_o != lv) bad++;
    end
    chk(bad == 0, "R7 pending cancelled", bad, 0);

    // R2: start from trigger pulse, one-shot
    wr(0, 3); mode_i = 1'b1;
    @(negedge clk); trg_i = 1'b1;
    @(negedge clk); trg_i = 1'b0;
    lv = out_o;
    @(negedge clk);
    chk(out_o != lv && cnt_o == 3, "R2 trigger start load", int'(cnt_o), 3);
    lv = out_o; bad = 0;
    repeat (4) begin
      @(negedge clk);
      if (out_o != lv) bad++;
    end
    chk(bad == 1, "R2 trigger pulse width", bad, 1);
    repeat (5) @(negedge clk);

    // R9 + R10: mode change and retrigger during a PWM run
    wr(0, 6); wr(1, 2); mode_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
    @(negedge clk); @(negedge clk);
    repeat (3) @(negedge clk);
    mode_i = 1'b1; trg_i = 1'b1;
    @(negedge clk); trg_i = 1'b0;
    stray = 0;
    watch(3);
    chk(seg_len[1] == 7, "R9 mode held (PWM continues)", seg_len[1], 7);
    chk(seg_len[0] == 3 && seg_len[2] == 3, "R10 retrigger ignored", seg_len[0], 3);
    chk(stray == 0, "R10 no stray irq", stray, 0);
    halt();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule